// File: doc/BRIEF.md
# Exception Vector Address Generator

This block sits next to a small in-order core and turns its exception and interrupt requests into a one-cycle redirect. When the block accepts a request, it outputs the new program counter. That address is the start of a table of one-word entries. Each entry's offset is four times a 3-bit cause code. The table base is either all zeros or the high base `0xFFFF0000`, and a select pin chooses between them.

Six sources feed the block:
- a pending reset, raised once when the block leaves reset;
- a data-access permission fault;
- an external interrupt request, gated by a mask bit that the block holds;
- an instruction-fetch permission fault;
- an unrecognised instruction in decode;
- a software-trap instruction in decode.

A fetch fault is not reported at fetch. It travels with its instruction through a parameterised number of pipeline stages. The fault is raised only when that instruction reaches decode, and it is dropped if the pipeline is flushed first.

All of these are plain control pins with no handshake. The core must act on the redirect in the cycle the strobe is high. No back-pressure path exists: the block assumes the core always accepts a redirect.

Top module: `exc_vector_gen`

## Requirements
- R1: While `rst_n` is low, `redirect_o` is 0 and `irq_mask_o` is 1. On the first rising edge after `rst_n` goes high, the block takes the reset cause (code 0): `redirect_o` is high for that cycle and `vec_addr_o` equals the selected base.
- R2: In a redirect cycle, `vec_addr_o` equals base + 4 × code. The base is `0xFFFF0000` if `hivec_i` was 1 at the taking edge, and `0x00000000` otherwise.
- R3: Cause codes are: 0 reset, 1 undefined instruction, 2 software trap, 3 fetch permission fault, 4 data permission fault, 6 interrupt request.
- R4: When several requests are present at the same edge, one is chosen in the fixed order reset, data fault, interrupt, fetch fault, undefined, software trap (first listed wins).
- R5: `irq_i` is ignored while `irq_mask_o` is 1. It is taken at an edge where the mask is 0.
- R6: Taking any cause sets `irq_mask_o` to 1. Otherwise, `mask_we_i` loads `mask_d_i` into the mask at the edge.
- R7: With `pipe_adv_i` high, a fetch captured with `fetch_vld_i` and `fetch_fault_i` high reaches decode after `FETCH_DEPTH` edges. The redirect with code 3 appears on the next edge.
- R8: A carried fetch fault is discarded when `flush_i` is high at an edge, or when another cause is taken at that edge.
- R9: `redirect_o` lasts exactly one cycle. Requests seen while it is high are not taken. Between redirects, `vec_addr_o` and `exc_code_o` hold their last values.
- R10: While `pipe_adv_i` is low, carried fetch faults hold their stage and raise nothing until they reach decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hivec_i | input | 1 | Select high table base |
| fetch_vld_i | input | 1 | An instruction is fetched this cycle |
| fetch_fault_i | input | 1 | That fetch lacked access permission |
| pipe_adv_i | input | 1 | Fetch-to-decode pipeline advances |
| flush_i | input | 1 | Core flushes the fetch-to-decode pipeline |
| undef_i | input | 1 | Decode cannot recognise the instruction |
| swi_i | input | 1 | Decode holds a software-trap instruction |
| dabt_i | input | 1 | Data access permission fault |
| irq_i | input | 1 | External interrupt request |
| mask_we_i | input | 1 | Write strobe for the interrupt mask |
| mask_d_i | input | 1 | Value to write into the interrupt mask |
| redirect_o | output | 1 | One-cycle redirect strobe |
| vec_addr_o | output | ADDR_W | Vector address |
| exc_code_o | output | 3 | Cause code of the last redirect |
| irq_mask_o | output | 1 | Current interrupt mask |

## Verification
Each kind of corrupted internal state shows up at the outputs within a few cycles:
- A lost or duplicated stage in the fetch-fault tracker moves the code-3 redirect one edge earlier or later than `FETCH_DEPTH` + 1 edges after capture.
- A tracker that ignores flushes produces a redirect that should never appear.
- A stuck mask register shows up as an interrupt that is taken while masked, or refused while unmasked, on the very next edge.
- A wrong priority or base shows in `exc_code_o` and `vec_addr_o` in the same cycle as the strobe.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd6
  } exc_code_e;

  typedef struct packed {
    logic rst;
    logic dabt;
    logic irq;
    logic pabt;
    logic undef;
    logic swi;
  } exc_req_t;
endpackage

// File: rtl/exc_fault_track.sv
// Carries a fetch-permission fault alongside its instruction until decode.
module exc_fault_track #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic flush_i,
  input  logic fault_i,
  output logic dec_fault_o
);
  logic [DEPTH-1:0] stg_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stg_q <= '0;
        else if (flush_i) stg_q <= '0;
        else if (adv_i)   stg_q <= fault_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stg_q <= '0;
        else if (flush_i) stg_q <= '0;
        else if (adv_i)   stg_q <= {stg_q[DEPTH-2:0], fault_i};
      end
    end
  endgenerate

  assign dec_fault_o = stg_q[DEPTH-1];
endmodule

// File: rtl/exc_prio_sel.sv
// Fixed-priority choice among pending causes.
module exc_prio_sel
  import exc_vec_pkg::*;
(
  input  exc_req_t          req_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  exc_code_e sel;

  always_comb begin
    sel = EXC_RESET;
    if      (req_i.rst)   sel = EXC_RESET;
    else if (req_i.dabt)  sel = EXC_DABT;
    else if (req_i.irq)   sel = EXC_IRQ;
    else if (req_i.pabt)  sel = EXC_PABT;
    else if (req_i.undef) sel = EXC_UNDEF;
    else if (req_i.swi)   sel = EXC_SWI;
  end

  assign any_o  = |req_i;
  assign code_o = sel;
endmodule

// File: rtl/exc_vec_addr.sv
// Table base selection plus word offset from the cause code.
module exc_vec_addr
  import exc_vec_pkg::*;
#(
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] LO_BASE = '0,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input  logic              hivec_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFF_W = CODE_W + 2;
  logic [OFF_W-1:0] offset;

  assign offset = {code_i, 2'b00};
  assign addr_o = (hivec_i ? HI_BASE : LO_BASE) + ADDR_W'(offset);
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
  import exc_vec_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                FETCH_DEPTH = 2,
  parameter logic [ADDR_W-1:0] LO_BASE     = '0,
  parameter logic [ADDR_W-1:0] HI_BASE     = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hivec_i,
  input  logic              fetch_vld_i,
  input  logic              fetch_fault_i,
  input  logic              pipe_adv_i,
  input  logic              flush_i,
  input  logic              undef_i,
  input  logic              swi_i,
  input  logic              dabt_i,
  input  logic              irq_i,
  input  logic              mask_we_i,
  input  logic              mask_d_i,
  output logic              redirect_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [2:0]        exc_code_o,
  output logic              irq_mask_o
);
  logic              rst_pend_q;
  logic              mask_q;
  logic              dec_fault;
  logic              any_req;
  logic              take;
  logic [CODE_W-1:0] sel_code;
  logic [ADDR_W-1:0] sel_addr;
  exc_req_t          req;

  // Fault tracker: a flush from the core or from a taken cause empties it.
  exc_fault_track #(.DEPTH(FETCH_DEPTH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (pipe_adv_i),
    .flush_i    (flush_i | take),
    .fault_i    (fetch_vld_i & fetch_fault_i),
    .dec_fault_o(dec_fault)
  );

  always_comb begin
    req.rst   = rst_pend_q;
    req.dabt  = dabt_i;
    req.irq   = irq_i & ~mask_q;
    req.pabt  = dec_fault;
    req.undef = undef_i;
    req.swi   = swi_i;
  end

  exc_prio_sel u_prio (
    .req_i (req),
    .any_o (any_req),
    .code_o(sel_code)
  );

  exc_vec_addr #(.ADDR_W(ADDR_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)) u_addr (
    .hivec_i(hivec_i),
    .code_i (sel_code),
    .addr_o (sel_addr)
  );

  // The strobe cycle is a flush cycle for the core, so nothing is taken in it.
  assign take = any_req & ~redirect_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pend_q <= 1'b1;
      mask_q     <= 1'b1;
      redirect_o <= 1'b0;
      vec_addr_o <= '0;
      exc_code_o <= '0;
    end else begin
      redirect_o <= take;
      if (take) begin
        rst_pend_q <= 1'b0;
        mask_q     <= 1'b1;
        vec_addr_o <= sel_addr;
        exc_code_o <= sel_code;
      end else if (mask_we_i) begin
        mask_q <= mask_d_i;
      end
    end
  end

  assign irq_mask_o = mask_q;
endmodule

// File: rtl/exc_vector_chk.sv
module exc_vector_chk #(
  parameter int                ADDR_W  = 32,
  parameter logic [ADDR_W-1:0] LO_BASE = '0,
  parameter logic [ADDR_W-1:0] HI_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hivec_i,
  input logic              irq_i,
  input logic              redirect_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [2:0]        exc_code_o,
  input logic              irq_mask_o
);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);

  assert_hold_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_o |-> ($stable(exc_code_o) && $stable(vec_addr_o)));

  assert_legal_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (exc_code_o != 3'd5 && exc_code_o != 3'd7));

  assert_vec_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (vec_addr_o == (($past(hivec_i) ? HI_BASE : LO_BASE) + ADDR_W'({exc_code_o, 2'b00}))));

  assert_mask_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> irq_mask_o);

  assert_irq_unmasked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && exc_code_o == 3'd6) |-> ($past(irq_i) && !$past(irq_mask_o)));
endmodule

bind exc_vector_gen exc_vector_chk #(
  .ADDR_W(ADDR_W), .LO_BASE(LO_BASE), .HI_BASE(HI_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hivec_i   (hivec_i),
  .irq_i     (irq_i),
  .redirect_o(redirect_o),
  .vec_addr_o(vec_addr_o),
  .exc_code_o(exc_code_o),
  .irq_mask_o(irq_mask_o)
);

// File: tb/tb_exc_vector_gen.sv
`timescale 1ns/1ps
module tb_exc_vector_gen;
  localparam int          FD = 2;
  localparam logic [31:0] HI = 32'hFFFF_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hivec_i = 0, fetch_vld_i = 0, fetch_fault_i = 0, pipe_adv_i = 0, flush_i = 0;
  logic undef_i = 0, swi_i = 0, dabt_i = 0, irq_i = 0, mask_we_i = 0, mask_d_i = 0;
  logic        redirect_o, irq_mask_o;
  logic [31:0] vec_addr_o;
  logic [2:0]  exc_code_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 0;

  always #10 clk = ~clk;  // 50 MHz

  exc_vector_gen #(.ADDR_W(32), .FETCH_DEPTH(FD)) dut (
    .clk(clk), .rst_n(rst_n), .hivec_i(hivec_i), .fetch_vld_i(fetch_vld_i),
    .fetch_fault_i(fetch_fault_i), .pipe_adv_i(pipe_adv_i), .flush_i(flush_i),
    .undef_i(undef_i), .swi_i(swi_i), .dabt_i(dabt_i), .irq_i(irq_i),
    .mask_we_i(mask_we_i), .mask_d_i(mask_d_i), .redirect_o(redirect_o),
    .vec_addr_o(vec_addr_o), .exc_code_o(exc_code_o), .irq_mask_o(irq_mask_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_addr(input bit hv, input logic [2:0] code);
    return (hv ? HI : 32'h0) + {27'd0, code, 2'b00};
  endfunction

  // Reference model built from the requirements
  bit          m_redir, m_mask, m_rpend;
  logic [2:0]  m_code;
  logic [31:0] m_addr;
  bit          m_fb[FD];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_redir = 0; m_mask = 1; m_rpend = 1; m_code = 0; m_addr = 0;
      for (int k = 0; k < FD; k++) m_fb[k] = 0;
    end else begin
      bit hit;
      logic [2:0] c;
      hit = 1; c = 0;
      if      (m_rpend)            c = 3'd0;
      else if (dabt_i)             c = 3'd4;
      else if (irq_i && !m_mask)   c = 3'd6;
      else if (m_fb[FD-1])         c = 3'd3;
      else if (undef_i)            c = 3'd1;
      else if (swi_i)              c = 3'd2;
      else                         hit = 0;
      if (hit && !m_redir) begin
        m_redir = 1; m_code = c; m_addr = exp_addr(hivec_i, c);
        m_mask = 1; m_rpend = 0;
        for (int k = 0; k < FD; k++) m_fb[k] = 0;
      end else begin
        m_redir = 0;
        if (mask_we_i) m_mask = mask_d_i;
        if (flush_i) begin
          for (int k = 0; k < FD; k++) m_fb[k] = 0;
        end else if (pipe_adv_i) begin
          for (int k = FD - 1; k > 0; k--) m_fb[k] = m_fb[k-1];
          m_fb[0] = fetch_vld_i & fetch_fault_i;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R9 redirect", {31'd0, redirect_o}, {31'd0, m_redir});
      chk("R3 code", {29'd0, exc_code_o}, {29'd0, m_code});
      chk("R2 address", vec_addr_o, m_addr);
      chk("R6 mask", {31'd0, irq_mask_o}, {31'd0, m_mask});
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) step();
    chk("R1 no redirect in reset", {31'd0, redirect_o}, 32'd0);
    chk("R1 mask set in reset", {31'd0, irq_mask_o}, 32'd1);
    pipe_adv_i = 1; fetch_vld_i = 1;
    rst_n = 1;
    step();
    chk("R1 reset redirect", {31'd0, redirect_o}, 32'd1);
    chk("R1 reset code", {29'd0, exc_code_o}, 32'd0);
    chk("R1 reset address", vec_addr_o, 32'h0);
    step();
    chk("R9 pulse ends", {31'd0, redirect_o}, 32'd0);

    mask_we_i = 1; mask_d_i = 0; step(); mask_we_i = 0;
    chk("R6 mask written", {31'd0, irq_mask_o}, 32'd0);

    // R4: all at once, high base
    dabt_i = 1; irq_i = 1; undef_i = 1; swi_i = 1; hivec_i = 1;
    step();
    dabt_i = 0; irq_i = 0; undef_i = 0; swi_i = 0; hivec_i = 0;
    chk("R4 data fault wins", {29'd0, exc_code_o}, 32'd4);
    chk("R2 high base", vec_addr_o, 32'hFFFF_0010);
    step();
    chk("R6 mask after take", {31'd0, irq_mask_o}, 32'd1);

    // R4: interrupt beats fetch fault and decode causes
    mask_we_i = 1; mask_d_i = 0; step(); mask_we_i = 0;
    irq_i = 1; undef_i = 1; swi_i = 1;
    step();
    irq_i = 0; undef_i = 0; swi_i = 0;
    chk("R4 irq over undef", {29'd0, exc_code_o}, 32'd6);
    step();

    // R5: masked interrupt ignored
    irq_i = 1;
    repeat (3) begin
      step();
      chk("R5 masked irq ignored", {31'd0, redirect_o}, 32'd0);
    end
    mask_we_i = 1; mask_d_i = 0;
    step();
    mask_we_i = 0;
    chk("R5 still no take", {31'd0, redirect_o}, 32'd0);
    step();
    irq_i = 0;
    chk("R5 irq taken", {31'd0, redirect_o}, 32'd1);
    chk("R5 irq code", {29'd0, exc_code_o}, 32'd6);
    chk("R2 irq address", vec_addr_o, 32'h18);
    step();

    // R7: fetch fault latency
    fetch_fault_i = 1;
    step();
    fetch_fault_i = 0;
    chk("R7 not at fetch", {31'd0, redirect_o}, 32'd0);
    repeat (FD - 1) begin
      step();
      chk("R7 not before decode", {31'd0, redirect_o}, 32'd0);
    end
    step();
    chk("R7 raised at decode", {31'd0, redirect_o}, 32'd1);
    chk("R7 code", {29'd0, exc_code_o}, 32'd3);
    chk("R2 prefetch address", vec_addr_o, 32'h0C);
    step();

    // R10: stall holds fault
    fetch_fault_i = 1;
    step();
    fetch_fault_i = 0; pipe_adv_i = 0;
    repeat (5) begin
      step();
      chk("R10 stalled no redirect", {31'd0, redirect_o}, 32'd0);
    end
    pipe_adv_i = 1;
    repeat (FD - 1) begin
      step();
      chk("R10 moving", {31'd0, redirect_o}, 32'd0);
    end
    step();
    chk("R10 raised after stall", {31'd0, redirect_o}, 32'd1);
    chk("R10 code", {29'd0, exc_code_o}, 32'd3);
    step();

    // R8: core flush drops fault
    fetch_fault_i = 1;
    step();
    fetch_fault_i = 0; flush_i = 1;
    step();
    flush_i = 0;
    repeat (FD + 2) begin
      step();
      chk("R8 flushed fault", {31'd0, redirect_o}, 32'd0);
    end

    // R8: taken cause drops fault
    fetch_fault_i = 1; swi_i = 1;
    step();
    fetch_fault_i = 0; swi_i = 0;
    chk("R8 swi taken", {29'd0, exc_code_o}, 32'd2);
    repeat (FD + 2) begin
      step();
      chk("R8 no late prefetch", {31'd0, redirect_o}, 32'd0);
    end

    // R9: held request, blocked strobe cycle
    undef_i = 1;
    step(); chk("R9 first take", {31'd0, redirect_o}, 32'd1);
    chk("R3 undef code", {29'd0, exc_code_o}, 32'd1);
    step(); chk("R9 blocked cycle", {31'd0, redirect_o}, 32'd0);
    step(); chk("R9 second take", {31'd0, redirect_o}, 32'd1);
    undef_i = 0;
    step(); chk("R9 hold code", {29'd0, exc_code_o}, 32'd1);

    // R1: reset with high base
    rst_n = 0; step(); step();
    hivec_i = 1; rst_n = 1;
    step();
    hivec_i = 0;
    chk("R1 reset high", vec_addr_o, HI);
    step();

    // Random phase
    cmp_en = 1;
    for (int i = 0; i < 4000; i++) begin
      hivec_i       = ($urandom % 2) == 0;
      fetch_vld_i   = ($urandom % 10) < 8;
      fetch_fault_i = ($urandom % 10) == 0;
      pipe_adv_i    = ($urandom % 10) < 8;
      flush_i       = ($urandom % 30) == 0;
      undef_i       = ($urandom % 30) == 0;
      swi_i         = ($urandom % 30) == 0;
      dabt_i        = ($urandom % 40) == 0;
      irq_i         = ($urandom % 8) == 0;
      mask_we_i     = ($urandom % 12) == 0;
      mask_d_i      = ($urandom % 3) != 0 ? 1'b0 : 1'b1;
      step();
    end
    cmp_en = 0;

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule